// File: doc/BRIEF.md
# Metering Register File with SPI Slave Port

This block is the serial register interface of a three-phase energy meter. An external host talks to it over a four-wire SPI link. The host sends a command byte and then a fixed number of data bytes. On a write those bytes load the addressed register. On a read the slave returns the register contents on MISO during those same byte slots. The number of data bytes depends on the address: it is the register's bit width rounded up to whole bytes.

The register file keeps each register's width, reset value, signedness and access right. It also holds three registers with side effects:
- A checksum register counts the one bits returned by the last completed read.
- A version register returns a fixed constant.
- A pair of status views share one set of event flags. The second view clears the flags it reported once its read completes.

The measurement arithmetic does not live here. Its result registers are loaded through a simple test port. Event flags arrive on a set-only input.

The SPI pins are sampled with the system clock. The parameter `SPI_MODE` selects mode 0 or mode 1 (clock idles low in both). Chip select may be held low for a whole session of back-to-back transfers. Raising it mid-transfer throws the partial transfer away.

Top module: `spi_meter_regfile`

## Requirements
- R1: The command byte carries the direction in bit 7 (1 = write, 0 = read) and the register address in bits 6:0. A write updates the register in a single clock cycle, once the last data bit has been sampled, and never on a partial byte.
- R2: The data-byte count is ceil(width/8): 1 byte for registers of 7 or 8 bits, 2 bytes for 12 or 16 bits, 3 bytes for 24 bits. With chip select held low, the byte after the last data byte is decoded as a new command.
- R3: Data is sent most significant byte first and most significant bit first, right-aligned in the byte field. On readout, signed 7- and 12-bit registers (addresses 0x24 to 0x41) are sign-extended to the full field. Writes keep only the register's width.
- R4: Reset values are as follows. Address 0x13 = 0x04, 0x14 = 0xFC, 0x16 = 0x1C, 0x17 = 0x78. Addresses 0x1B and 0x1C = 0xFFFF. Addresses 0x1D, 0x1F and 0x20 = 0xFF. Addresses 0x46 and 0x48 = 0x3F. Every other register resets to 0, and MISO is 0 after reset.
- R5: SPI writes to the read-only addresses are ignored. These are 0x01 to 0x12, 0x19, 0x1A, 0x21, 0x22, 0x7E and 0x7F. Of them, 0x01 to 0x12, 0x21 and 0x22 can be loaded only through the test port, which masks the value to the register width. The test port ignores every other address.
- R6: Unmapped addresses read as zero, ignore writes, and take one data byte.
- R7: Address 0x7E returns the number of one bits in the data bytes shifted out by the most recent completed read. An aborted read leaves it unchanged.
- R8: Address 0x7F returns the constant `DIE_VERSION` (default 0x11).
- R9: Addresses 0x19 and 0x1A both return the 24-bit flag register. Flags are set from `status_set`. Reading 0x19 has no side effect. A completed read of 0x1A clears the flags it returned. A flag set in the clearing cycle or later survives.
- R10: If chip select rises before the last data byte is complete, the transfer is discarded: no register, flag or checksum changes, and the next byte is a command.
- R11: With `SPI_MODE` = 0, MOSI is sampled on the rising SCLK edge and MISO changes on the falling edge. With `SPI_MODE` = 1 the roles of the edges are swapped. Read data is captured when the command byte completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock, idles low |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| meas_we | input | 1 | Test-port load strobe for measurement registers |
| meas_addr | input | 7 | Test-port register address |
| meas_data | input | 24 | Test-port value, right-aligned |
| status_set | input | 24 | Per-cycle flag set pulses |

## Verification
The embedded assertions check every cycle that:
- a high chip select returns the transfer counters to idle;
- the byte index never passes the byte count;
- a new flag is never lost and no flag drops without a completed clearing read;
- the checksum stays in range;
- a sample register changes only on a byte boundary or through the test port.

The address-dependent byte counts, reset values, sign extension, read-only masking and checksum values are shown only by the bench. It reads every address after reset, writes every address, and reads every address again. Chip-select aborts, back-to-back transfers with chip select held low, and the mode-1 edge order are likewise exercised only by the bench's scenarios.

// File: rtl/spi_meter_regfile.sv
module spi_meter_regfile #(
  parameter int         SPI_MODE    = 0,
  parameter logic [7:0] DIE_VERSION = 8'h11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        cs_n,
  input  logic        mosi,
  output logic        miso,
  input  logic        meas_we,
  input  logic [6:0]  meas_addr,
  input  logic [23:0] meas_data,
  input  logic [23:0] status_set
);
  localparam int         DW        = 24;
  localparam int         NREG      = 128;
  localparam logic [6:0] A_STAT    = 7'h19;
  localparam logic [6:0] A_STAT_RC = 7'h1A;
  localparam logic [6:0] A_CHK     = 7'h7E;
  localparam logic [6:0] A_VER     = 7'h7F;

  function automatic logic [4:0] width_of(input logic [6:0] a);
    if (a >= 7'h01 && a <= 7'h09) return 5'd16;
    if (a >= 7'h0A && a <= 7'h0F) return 5'd24;
    if (a == 7'h10) return 5'd12;
    if (a == 7'h11) return 5'd8;
    if (a == 7'h12) return 5'd24;
    if (a >= 7'h13 && a <= 7'h17) return 5'd8;
    if (a >= 7'h18 && a <= 7'h1A) return 5'd24;
    if (a == 7'h1B || a == 7'h1C) return 5'd16;
    if (a >= 7'h1D && a <= 7'h23) return 5'd8;
    if (a >= 7'h24 && a <= 7'h3E) return 5'd12;
    if (a >= 7'h3F && a <= 7'h41) return 5'd7;
    if (a >= 7'h42 && a <= 7'h44) return 5'd8;
    if (a == 7'h45 || a == 7'h47) return 5'd16;
    if (a == 7'h46 || a == 7'h48) return 5'd12;
    if (a == A_CHK || a == A_VER) return 5'd8;
    return 5'd0;
  endfunction

  function automatic logic is_signed(input logic [6:0] a);
    return (a >= 7'h01 && a <= 7'h0F) || a == 7'h11 || a == 7'h12 ||
           (a >= 7'h24 && a <= 7'h41);
  endfunction

  function automatic logic measured(input logic [6:0] a);
    return (a >= 7'h01 && a <= 7'h12) || a == 7'h21 || a == 7'h22;
  endfunction

  function automatic logic read_only(input logic [6:0] a);
    return measured(a) || a == A_STAT || a == A_STAT_RC || a == A_CHK || a == A_VER;
  endfunction

  function automatic logic [23:0] init_of(input logic [6:0] a);
    case (a)
      7'h13:                return 24'h04;
      7'h14:                return 24'hFC;
      7'h16:                return 24'h1C;
      7'h17:                return 24'h78;
      7'h1B, 7'h1C:         return 24'hFFFF;
      7'h1D, 7'h1F, 7'h20:  return 24'hFF;
      7'h46, 7'h48:         return 24'h3F;
      default:              return 24'h0;
    endcase
  endfunction

  function automatic logic [DW-1:0] mask_of(input logic [4:0] w);
    logic [DW:0] t;
    t = (25'd1 << w) - 25'd1;
    return t[DW-1:0];
  endfunction

  function automatic logic [1:0] nbytes_of(input logic [6:0] a);
    logic [5:0] w;
    w = {1'b0, width_of(a)};
    if (w == 6'd0) return 2'd1;
    w = (w + 6'd7) >> 3;
    return w[1:0];
  endfunction

  function automatic logic [7:0] popcount(input logic [DW-1:0] v);
    logic [7:0] c;
    c = 8'd0;
    for (int i = 0; i < DW; i++) c = c + {7'd0, v[i]};
    return c;
  endfunction

  logic [2:0]    sclk_s;
  logic [1:0]    cs_s, mosi_s;
  logic          cs_act, sc_rise, sc_fall, samp, shft;
  logic [2:0]    bit_cnt;
  logic [1:0]    byte_idx, need_q;
  logic [7:0]    cmd_q, in_sr, chk_q;
  logic [7:0]    in_byte;
  logic [DW-1:0] wr_acc, wr_word, out_sr, rd_hold, status_q;
  logic          miso_q;
  logic [DW-1:0] regs_q [NREG];
  logic          byte_done, at_cmd, last_byte, do_wr, do_rd, rc_clear;
  logic [6:0]    cmd_addr, rd_addr;
  logic [DW-1:0] rd_raw, rd_ext, rd_val, rd_top;
  logic [4:0]    rd_w;
  logic [1:0]    rd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= '0;
      cs_s   <= 2'b11;
      mosi_s <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk};
      cs_s   <= {cs_s[0], cs_n};
      mosi_s <= {mosi_s[0], mosi};
    end
  end

  assign cs_act  = ~cs_s[1];
  assign sc_rise = sclk_s[1] & ~sclk_s[2];
  assign sc_fall = ~sclk_s[1] & sclk_s[2];
  assign samp    = cs_act & ((SPI_MODE == 0) ? sc_rise : sc_fall);
  assign shft    = cs_act & ((SPI_MODE == 0) ? sc_fall : sc_rise);

  assign in_byte   = {in_sr[6:0], mosi_s[1]};
  assign byte_done = samp & (bit_cnt == 3'd7);
  assign at_cmd    = (byte_idx == 2'd0);
  assign cmd_addr  = cmd_q[6:0];
  assign last_byte = byte_done & ~at_cmd & (byte_idx == need_q);
  assign wr_word   = {wr_acc[15:0], in_byte};
  assign do_wr     = last_byte & cmd_q[7] & ~read_only(cmd_addr) & (width_of(cmd_addr) != 5'd0);
  assign do_rd     = last_byte & ~cmd_q[7];
  assign rc_clear  = do_rd & (cmd_addr == A_STAT_RC);

  assign rd_addr = in_byte[6:0];
  always_comb begin
    rd_w = width_of(rd_addr);
    rd_n = nbytes_of(rd_addr);
    case (rd_addr)
      A_STAT, A_STAT_RC: rd_raw = status_q;
      A_CHK:             rd_raw = {16'h0, chk_q};
      A_VER:             rd_raw = {16'h0, DIE_VERSION};
      default:           rd_raw = regs_q[rd_addr];
    endcase
    rd_top = mask_of(rd_w) ^ (mask_of(rd_w) >> 1);
    rd_ext = rd_raw;
    if (is_signed(rd_addr) && |(rd_raw & rd_top)) rd_ext = rd_raw | ~mask_of(rd_w);
    case (rd_n)
      2'd1:    rd_val = rd_ext & 24'h0000FF;
      2'd2:    rd_val = rd_ext & 24'h00FFFF;
      default: rd_val = rd_ext;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      byte_idx <= '0;
      need_q   <= 2'd1;
      cmd_q    <= '0;
      in_sr    <= '0;
      wr_acc   <= '0;
      out_sr   <= '0;
      rd_hold  <= '0;
      miso_q   <= 1'b0;
      chk_q    <= '0;
    end else if (!cs_act) begin
      bit_cnt  <= '0;
      byte_idx <= '0;
      miso_q   <= 1'b0;
    end else begin
      if (samp) begin
        in_sr   <= in_byte;
        bit_cnt <= bit_cnt + 3'd1;
        if (byte_done) begin
          if (at_cmd) begin
            cmd_q    <= in_byte;
            need_q   <= rd_n;
            wr_acc   <= '0;
            rd_hold  <= rd_val;
            byte_idx <= 2'd1;
            case (rd_n)
              2'd1:    out_sr <= {rd_val[7:0], 16'h0};
              2'd2:    out_sr <= {rd_val[15:0], 8'h0};
              default: out_sr <= rd_val;
            endcase
          end else begin
            wr_acc <= wr_word;
            if (last_byte) begin
              byte_idx <= 2'd0;
              if (do_rd) chk_q <= popcount(rd_hold);
            end else begin
              byte_idx <= byte_idx + 2'd1;
            end
          end
        end
      end
      if (shft) begin
        miso_q <= out_sr[DW-1];
        out_sr <= {out_sr[DW-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= init_of(7'(i));
    end else begin
      if (do_wr) regs_q[cmd_addr] <= wr_word & mask_of(width_of(cmd_addr));
      if (meas_we && measured(meas_addr)) regs_q[meas_addr] <= meas_data & mask_of(width_of(meas_addr));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~(rc_clear ? rd_hold : 24'h0)) | status_set;
  end

  assign miso = miso_q;

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (byte_idx == 2'd0 && bit_cnt == 3'd0));  // R10
  AST_BYTE_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (need_q != 2'd0) && (byte_idx <= need_q));  // R2
  AST_SET_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (status_set != 24'h0) |=> ((status_q & $past(status_set)) == $past(status_set)));  // R9
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rc_clear |=> ((status_q & $past(status_q)) == $past(status_q)));  // R9
  AST_MEAS_ONLY_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_we |=> $stable(regs_q[7'h0A]));  // R5
  AST_WRITE_WHOLE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_done |=> $stable(regs_q[7'h13]));  // R1
  AST_CHK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    chk_q <= 8'd24);  // R7
endmodule

// File: tb/spi_meter_regfile_tb_top.sv
module spi_meter_regfile_tb_top;
  localparam int         H   = 5;
  localparam logic [7:0] VER = 8'h11;

  logic        clk, rst_n;
  logic [1:0]  sclk_v, cs_n_v, mosi_v, miso_v;
  logic        meas_we;
  logic [6:0]  meas_addr;
  logic [23:0] meas_data, status_set;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  logic [23:0] mem_m [128];
  logic [23:0] stat_m;
  logic [7:0]  last_pop [2];

  spi_meter_regfile #(.SPI_MODE(0), .DIE_VERSION(VER)) dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk_v[0]), .cs_n(cs_n_v[0]), .mosi(mosi_v[0]),
    .miso(miso_v[0]), .meas_we(meas_we), .meas_addr(meas_addr), .meas_data(meas_data),
    .status_set(status_set));
  spi_meter_regfile #(.SPI_MODE(1), .DIE_VERSION(VER)) dut_m1_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk_v[1]), .cs_n(cs_n_v[1]), .mosi(mosi_v[1]),
    .miso(miso_v[1]), .meas_we(meas_we), .meas_addr(meas_addr), .meas_data(meas_data),
    .status_set(status_set));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000 && !done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int m_width(input logic [6:0] a);
    if (a >= 1 && a <= 9) return 16;
    if ((a >= 8'h0A && a <= 8'h0F) || a == 8'h12 || (a >= 8'h18 && a <= 8'h1A)) return 24;
    if (a == 8'h10) return 12;
    if (a == 8'h11 || (a >= 8'h13 && a <= 8'h17) || (a >= 8'h1D && a <= 8'h23)) return 8;
    if (a == 8'h1B || a == 8'h1C || a == 8'h45 || a == 8'h47) return 16;
    if ((a >= 8'h24 && a <= 8'h3E) || a == 8'h46 || a == 8'h48) return 12;
    if (a >= 8'h3F && a <= 8'h41) return 7;
    if ((a >= 8'h42 && a <= 8'h44) || a >= 8'h7E) return 8;
    return 0;
  endfunction

  function automatic int m_nb(input logic [6:0] a);
    return (m_width(a) == 0) ? 1 : (m_width(a) + 7) / 8;
  endfunction

  function automatic bit m_meas(input logic [6:0] a);
    return (a >= 1 && a <= 8'h12) || a == 8'h21 || a == 8'h22;
  endfunction

  function automatic bit m_writable(input logic [6:0] a);
    return m_width(a) != 0 && !m_meas(a) && a != 8'h19 && a != 8'h1A && a < 8'h7E;
  endfunction

  function automatic logic [23:0] m_mask(input int w);
    return 24'((25'd1 << w) - 1);
  endfunction

  function automatic logic [23:0] m_init(input logic [6:0] a);
    case (a)
      7'h13: return 24'h04;
      7'h14: return 24'hFC;
      7'h16: return 24'h1C;
      7'h17: return 24'h78;
      7'h1B, 7'h1C: return 24'hFFFF;
      7'h1D, 7'h1F, 7'h20: return 24'hFF;
      7'h46, 7'h48: return 24'h3F;
      default: return 24'h0;
    endcase
  endfunction

  function automatic logic [7:0] pop(input logic [23:0] v);
    logic [7:0] c = 0;
    for (int i = 0; i < 24; i++) c = c + {7'd0, v[i]};
    return c;
  endfunction

  function automatic logic [23:0] exp_read(input logic [6:0] a);
    logic [23:0] v;
    int w = m_width(a);
    if (a == 7'h19 || a == 7'h1A) v = stat_m;
    else if (a == 7'h7E) v = {16'h0, last_pop[0]};
    else if (a == 7'h7F) v = {16'h0, VER};
    else v = mem_m[a];
    if (a >= 8'h24 && a <= 8'h41 && v[w-1]) v = v | ~m_mask(w);
    return v & m_mask(8 * m_nb(a));
  endfunction

  function automatic string tag_of(input logic [6:0] a);
    if (a == 7'h7E) return "R7 checksum";
    if (a == 7'h7F) return "R8 version";
    if (a == 7'h19 || a == 7'h1A) return "R9 status";
    if (m_width(a) == 0) return "R6 unmapped";
    if (a >= 8'h24 && a <= 8'h41) return "R3 signed";
    if (m_meas(a)) return "R5 read-only";
    return "R1 register";
  endfunction

  task automatic clk_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] expv);
    checks = checks + 1;
    if (act !== expv) begin
      errors = errors + 1;
      $display("FAIL %s: got %h expected %h", req, act, expv);
    end
  endtask

  task automatic xfer(input int m, input logic [7:0] cmd, input int n, input logic [23:0] wd,
                      input bit keep, input int limit, output logic [23:0] rd);
    logic [31:0] frame;
    logic bitv;
    int total;
    total = 8 * (n + 1);
    frame = {cmd, 24'(wd << (8 * (3 - n)))};
    rd = '0;
    if (cs_n_v[m]) begin
      cs_n_v[m] = 1'b0;
      clk_wait(3);
    end
    for (int b = 0; b < total && b < limit; b++) begin
      if (m == 0) begin
        mosi_v[m] = frame[31-b];
        clk_wait(H);
        sclk_v[m] = 1'b1;
        bitv = miso_v[m];
        clk_wait(H);
        sclk_v[m] = 1'b0;
      end else begin
        sclk_v[m] = 1'b1;
        mosi_v[m] = frame[31-b];
        clk_wait(H);
        sclk_v[m] = 1'b0;
        bitv = miso_v[m];
        clk_wait(H);
      end
      if (b >= 8) rd = {rd[22:0], bitv};
    end
    clk_wait(4);
    if (!keep || limit < total) begin
      cs_n_v[m] = 1'b1;
      clk_wait(4);
    end
  endtask

  task automatic rd_check(input logic [6:0] a, input bit keep, input string req);
    logic [23:0] r, e;
    e = exp_read(a);
    xfer(0, {1'b0, a}, m_nb(a), 24'h0, keep, 99, r);
    chk($sformatf("%s addr %h", req, a), r, e);
    last_pop[0] = pop(r);
    if (a == 7'h1A) stat_m = 24'h0;
  endtask

  task automatic wr(input int m, input logic [6:0] a, input logic [23:0] d, input bit keep);
    logic [23:0] r;
    xfer(m, {1'b1, a}, m_nb(a), d, keep, 99, r);
    if (m == 0 && m_writable(a)) mem_m[a] = d & m_mask(m_width(a));
  endtask

  task automatic meas_load(input logic [6:0] a, input logic [23:0] d);
    meas_addr = a;
    meas_data = d;
    meas_we = 1'b1;
    clk_wait(1);
    meas_we = 1'b0;
    clk_wait(1);
    if (m_meas(a)) mem_m[a] = d & m_mask(m_width(a));
  endtask

  initial begin
    logic [23:0] r;
    rst_n = 1'b0;
    sclk_v = '0;
    cs_n_v = 2'b11;
    mosi_v = '0;
    meas_we = 1'b0;
    meas_addr = '0;
    meas_data = '0;
    status_set = '0;
    stat_m = '0;
    last_pop[0] = 0;
    last_pop[1] = 0;
    for (int i = 0; i < 128; i++) mem_m[i] = m_init(7'(i));
    clk_wait(5);
    rst_n = 1'b1;
    clk_wait(3);

    chk("R4 miso idle after reset", {22'h0, miso_v}, 24'h0);

    // R4 R6 R7 R8: every address after reset
    for (int a = 0; a < 128; a++) rd_check(7'(a), 1'b0, $sformatf("R4 reset %s", tag_of(7'(a))));

    // R5: measurement loads through the test port
    meas_load(7'h0A, 24'h812345);
    meas_load(7'h01, 24'h18001);
    meas_load(7'h10, 24'hFFFF);
    meas_load(7'h21, 24'h5A);
    meas_load(7'h13, 24'h99);
    rd_check(7'h0A, 1'b0, "R5 test port 24-bit");
    rd_check(7'h01, 1'b0, "R5 test port 16-bit masked");
    rd_check(7'h10, 1'b0, "R5 test port 12-bit masked");
    rd_check(7'h21, 1'b0, "R5 test port peak");
    rd_check(7'h13, 1'b0, "R5 test port ignores config");

    // R1 R3 R5 R6: write every address, then read everything back
    for (int a = 0; a < 128; a++) wr(0, 7'(a), 24'((a + 1) * 24'h9C3A5), 1'b0);
    for (int a = 0; a < 128; a++) rd_check(7'(a), 1'b0, $sformatf("R1 write sweep %s", tag_of(7'(a))));

    // R3: explicit sign extension corners
    wr(0, 7'h24, 24'h0800, 1'b0);
    rd_check(7'h24, 1'b0, "R3 12-bit negative");
    chk("R3 12-bit value", exp_read(7'h24), 24'hF800);
    wr(0, 7'h3F, 24'hFF, 1'b0);
    rd_check(7'h3F, 1'b0, "R3 7-bit negative");
    wr(0, 7'h40, 24'h3F, 1'b0);
    rd_check(7'h40, 1'b0, "R3 7-bit positive");

    // R2: back-to-back transfers with chip select held low
    wr(0, 7'h1B, 24'hBEEF, 1'b1);
    wr(0, 7'h14, 24'h3C, 1'b1);
    rd_check(7'h1B, 1'b1, "R2 cs low 2-byte");
    rd_check(7'h0A, 1'b1, "R2 cs low 3-byte");
    rd_check(7'h55, 1'b1, "R2 cs low unmapped 1-byte");
    rd_check(7'h14, 1'b0, "R2 cs low 1-byte");

    // R9: status views
    @(negedge clk);
    status_set = 24'h800101;
    clk_wait(1);
    status_set = 24'h0;
    stat_m = 24'h800101;
    clk_wait(2);
    rd_check(7'h19, 1'b0, "R9 plain status");
    rd_check(7'h19, 1'b0, "R9 plain status no clear");
    rd_check(7'h1A, 1'b0, "R9 clearing status");
    rd_check(7'h19, 1'b0, "R9 cleared after read");

    // R10: aborted transfers
    status_set = 24'h000010;
    clk_wait(1);
    status_set = 24'h0;
    stat_m = 24'h000010;
    xfer(0, 8'h1A, 3, 24'h0, 1'b0, 12, r);
    rd_check(7'h19, 1'b0, "R10 aborted read keeps flags");
    xfer(0, 8'h9B, 2, 24'h1111, 1'b0, 16, r);
    rd_check(7'h1B, 1'b0, "R10 aborted write keeps value");
    xfer(0, 8'h7E, 1, 24'h0, 1'b0, 4, r);
    rd_check(7'h14, 1'b0, "R10 command after mid-command abort");
    xfer(0, 8'h0A, 3, 24'h0, 1'b0, 20, r);
    rd_check(7'h7E, 1'b0, "R7 R10 checksum after aborted read");

    // R11: mode 1 instance
    xfer(1, 8'h17, 1, 24'h0, 1'b0, 99, r);
    chk("R11 mode1 reset read", r, 24'h78);
    wr(1, 7'h2A, 24'h0FFF, 1'b0);
    xfer(1, 8'h2A, 2, 24'h0, 1'b0, 99, r);
    chk("R11 mode1 write readback signed", r, 24'hFFFF);
    xfer(1, 8'h7F, 1, 24'h0, 1'b1, 99, r);
    chk("R11 mode1 version", r, {16'h0, VER});
    xfer(1, 8'h7E, 1, 24'h0, 1'b0, 99, r);
    chk("R11 mode1 checksum", r, {16'h0, pop({16'h0, VER})});

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule